// File: doc/BRIEF.md
# Register-Driven Two-Wire Byte Master

This block is a master for a two-wire serial bus of the I2C kind, used to reach a small serial memory or a similar slave. Software sees four byte-wide registers: a data byte, an index byte (the word address inside the slave), a slave-address byte that holds a 7-bit address together with a read/write bit, and a control/status byte. Software fills data and index, then writes the slave-address register. That one write launches the whole bus transaction. Software then polls a busy bit until the block is idle.

Three transaction shapes are produced. A byte write sends the address, the index and the data byte. A byte read first sends the address and the index in write direction. It then issues a repeated start and the address in read direction, clocks in one byte, answers it with a master NACK and sends a stop. A quick command sends only the address byte and then a stop.

SCL is generated from the system clock in quarter-bit steps. SDA and SCL are open-drain: the block only ever pulls a line low or releases it. A slave that does not acknowledge a byte sent by the master raises a sticky error flag, and the transaction then ends at once with a stop.

Top module: `tw_host_master`

## Requirements
- R1: Register offsets on `reg_addr`: 0 = data, 1 = index, 2 = slave address (bits 7:1 address, bit 0 = 1 for read), 3 = control/status (bit 0 quick-command enable, bit 4 NACK error, bit 5 busy, other bits read 0). After reset all registers read 0 and neither bus line is pulled low.
- R2: While idle, a write to offset 2 starts a transaction. The busy bit reads 1 from the clock edge that takes that write until the final stop has completed.
- R3: A byte write (read bit 0, quick off) puts on the bus: start, address byte with R/W=0, slave ACK, index byte, slave ACK, data byte, slave ACK, stop.
- R4: A byte read (read bit 1, quick off) sends start, address with R/W=0, index, a repeated start, address with R/W=1, then receives one byte, answers it with NACK and sends a stop. The received byte is in the data register when busy clears.
- R5: With quick enabled, only the address byte (carrying the programmed R/W bit) is sent between start and stop. The index and data registers are not transmitted.
- R6: SDA changes while SCL is high only as a start (falling SDA) or stop (rising SDA). Every other SDA change happens while SCL is low.
- R7: Every byte is sent and received most significant bit first.
- R8: While a transaction runs, successive SCL rising edges are 4*QDIV clocks apart and SCL stays high for 2*QDIV clocks in each bit.
- R9: If the slave leaves SDA high in the acknowledge slot of any byte sent by the master, bit 4 is set, no further byte is sent, a stop follows, and the data register is not loaded.
- R10: Bit 4 stays set through later successful transactions and through writes with bit 4 at 0. It is cleared only by writing 1 to bit 4 of offset 3.
- R11: While busy, writes to offsets 0, 1 and 2 and to the quick bit are ignored, and no second transaction is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register offset for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register at `reg_addr` (combinational) |
| scl_pull_low | output | 1 | 1 pulls the SCL line low, 0 releases it |
| sda_pull_low | output | 1 | 1 pulls the SDA line low, 0 releases it |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The hardest cases to reach are the ones decided on the wire: an address NACK, the master's own NACK after a read byte, and register writes that arrive while a transaction is running. The bench attaches a bus-level slave model that decodes start, stop and bits from the sampled lines and drives acknowledges and read data. A NACK is produced by aiming the master at an address the model does not answer. Mid-transaction register writes are issued right after launch, and their effect is judged from the bus and from the register read-back once busy drops.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;

    localparam logic [1:0] OFS_DATA  = 2'd0;
    localparam logic [1:0] OFS_INDEX = 2'd1;
    localparam logic [1:0] OFS_SLAVE = 2'd2;
    localparam logic [1:0] OFS_CTRL  = 2'd3;

    localparam int CTRL_QUICK = 0;
    localparam int CTRL_NACK  = 4;
    localparam int CTRL_BUSY  = 5;

    // bus symbol being played out, four quarters each
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BYTE,
        ST_STOP
    } sym_e;

    // which byte of the transaction is on the wire
    typedef enum logic [2:0] {
        STEP_ADDR,
        STEP_INDEX,
        STEP_WDATA,
        STEP_RADDR,
        STEP_RDATA
    } step_e;

    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
        logic       quick;
        logic [7:0] index;
        logic [7:0] wdata;
    } job_t;

    function automatic logic [7:0] byte_for(step_e s, job_t j);
        logic [7:0] b;
        case (s)
            STEP_ADDR:  b = {j.addr, (j.quick ? j.rd : 1'b0)};
            STEP_INDEX: b = j.index;
            STEP_WDATA: b = j.wdata;
            STEP_RADDR: b = {j.addr, 1'b1};
            default:    b = 8'hFF;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tw_qtick.sv
`timescale 1ns/1ps
module tw_qtick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R8: quarter ticks are never back to back when DIV > 1
            p_tick_gap_r8: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/tw_regs.sv
`timescale 1ns/1ps
module tw_regs
    import tw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       eng_busy,
    input  logic       nack_evt,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       go,
    output job_t       job
);
    logic [7:0] data_q, index_q, slave_q;
    logic       quick_q, nack_q, go_q;
    logic       busy_all, wr_ok, clr_nack;

    assign busy_all = eng_busy | go_q;
    assign wr_ok    = wr_en && !busy_all;
    assign clr_nack = wr_en && (addr == OFS_CTRL) && wdata[CTRL_NACK];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            index_q <= '0;
            slave_q <= '0;
            quick_q <= 1'b0;
            nack_q  <= 1'b0;
            go_q    <= 1'b0;
        end else begin
            go_q <= wr_ok && (addr == OFS_SLAVE);
            if (rx_valid)                           data_q <= rx_byte;
            else if (wr_ok && addr == OFS_DATA)     data_q <= wdata;
            if (wr_ok && addr == OFS_INDEX)         index_q <= wdata;
            if (wr_ok && addr == OFS_SLAVE)         slave_q <= wdata;
            if (wr_ok && addr == OFS_CTRL)          quick_q <= wdata[CTRL_QUICK];
            if (nack_evt)                           nack_q <= 1'b1;
            else if (clr_nack)                      nack_q <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            OFS_DATA:  rdata = data_q;
            OFS_INDEX: rdata = index_q;
            OFS_SLAVE: rdata = slave_q;
            default: begin
                rdata = '0;
                rdata[CTRL_QUICK] = quick_q;
                rdata[CTRL_NACK]  = nack_q;
                rdata[CTRL_BUSY]  = busy_all;
            end
        endcase
    end

    assign go        = go_q;
    assign job.addr  = slave_q[7:1];
    assign job.rd    = slave_q[0];
    assign job.quick = quick_q;
    assign job.index = index_q;
    assign job.wdata = data_q;

    // R11: a busy block keeps its index register
    p_locked_index_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy_all && addr == OFS_INDEX) |=> $stable(index_q));

    // R11: no launch while a transaction is in flight
    p_no_relaunch_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && eng_busy) |=> !go_q);

    // R10: error flag holds unless explicitly cleared
    p_nack_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (nack_q && !clr_nack) |=> nack_q);

endmodule

// File: rtl/tw_seq.sv
`timescale 1ns/1ps
module tw_seq
    import tw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  job_t       job,
    input  logic       tick,
    input  logic       sda_in,
    output logic       scl_lvl,
    output logic       sda_lvl,
    output logic       busy,
    output logic       nack_evt,
    output logic       rx_valid,
    output logic [7:0] rx_byte
);
    sym_e       st;
    step_e      step;
    logic [1:0] q;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic       ack_bad;
    job_t       jq;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            step     <= STEP_ADDR;
            q        <= '0;
            bitn     <= '0;
            sh       <= '0;
            ack_bad  <= 1'b0;
            jq       <= '0;
            nack_evt <= 1'b0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            nack_evt <= 1'b0;
            rx_valid <= 1'b0;
            if (st == ST_IDLE) begin
                if (go) begin
                    jq   <= job;
                    st   <= ST_START;
                    step <= STEP_ADDR;
                    q    <= '0;
                end
            end else if (tick) begin
                q <= q + 2'd1;
                // sample point: end of the second high quarter
                if (st == ST_BYTE && q == 2'd2) begin
                    if (bitn == 4'd8)            ack_bad <= sda_in;
                    else if (step == STEP_RDATA) sh <= {sh[6:0], sda_in};
                end
                if (q == 2'd3) begin
                    case (st)
                        ST_START: begin
                            st   <= ST_BYTE;
                            bitn <= '0;
                            sh   <= byte_for(step, jq);
                        end
                        ST_STOP: st <= ST_IDLE;
                        default: begin
                            if (bitn != 4'd8) begin
                                bitn <= bitn + 4'd1;
                                if (step != STEP_RDATA) sh <= {sh[6:0], 1'b0};
                            end else begin
                                bitn <= '0;
                                if (step != STEP_RDATA && ack_bad) begin
                                    nack_evt <= 1'b1;
                                    st       <= ST_STOP;
                                end else begin
                                    case (step)
                                        STEP_ADDR: begin
                                            if (jq.quick) st <= ST_STOP;
                                            else begin
                                                step <= STEP_INDEX;
                                                sh   <= byte_for(STEP_INDEX, jq);
                                            end
                                        end
                                        STEP_INDEX: begin
                                            if (jq.rd) begin
                                                st   <= ST_START;
                                                step <= STEP_RADDR;
                                            end else begin
                                                step <= STEP_WDATA;
                                                sh   <= byte_for(STEP_WDATA, jq);
                                            end
                                        end
                                        STEP_RADDR: begin
                                            step <= STEP_RDATA;
                                            sh   <= 8'hFF;
                                        end
                                        STEP_RDATA: begin
                                            rx_valid <= 1'b1;
                                            rx_byte  <= sh;
                                            st       <= ST_STOP;
                                        end
                                        default: st <= ST_STOP;
                                    endcase
                                end
                            end
                        end
                    endcase
                end
            end
        end
    end

    // line levels: quarters 1 and 2 of a bit hold SCL high
    always_comb begin
        case (st)
            ST_IDLE:  begin scl_lvl = 1'b1;                    sda_lvl = 1'b1;  end
            ST_START: begin scl_lvl = (q == 2'd1 || q == 2'd2); sda_lvl = !q[1]; end
            ST_STOP:  begin scl_lvl = (q != 2'd0);              sda_lvl = q[1];  end
            default: begin
                scl_lvl = (q == 2'd1 || q == 2'd2);
                sda_lvl = (bitn == 4'd8 || step == STEP_RDATA) ? 1'b1 : sh[7];
            end
        endcase
    end

    assign busy = (st != ST_IDLE);

    // R6: SDA moves under a high SCL only inside start or stop symbols
    p_sda_high_scl_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(scl_lvl) && scl_lvl && (sda_lvl != $past(sda_lvl)))
            |-> (st == ST_START || st == ST_STOP));

    // R2: a launch moves the engine straight into a start symbol
    p_start_on_go_r2: assert property (@(posedge clk) disable iff (rst)
        (go && st == ST_IDLE) |=> (st == ST_START && busy));

    // R9: slave NACK lands the engine in the stop symbol
    p_nack_stops_r9: assert property (@(posedge clk) disable iff (rst)
        nack_evt |-> (st == ST_STOP && !rx_valid));

    // R4: received bytes only come from non-quick reads
    p_rx_read_only_r4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (jq.rd && !jq.quick));

    // R8: quarter position only advances on a tick
    p_quarter_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(q));

endmodule

// File: rtl/tw_host_master.sv
`timescale 1ns/1ps
module tw_host_master
    import tw_pkg::*;
#(
    parameter int QDIV = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       scl_pull_low,
    output logic       sda_pull_low,
    input  logic       sda_in
);
    job_t       job;
    logic       go, busy, tick, nack_evt, rx_valid;
    logic       scl_lvl, sda_lvl;
    logic [7:0] rx_byte;

    tw_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .eng_busy (busy),
        .nack_evt (nack_evt),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .go       (go),
        .job      (job)
    );

    tw_qtick #(.DIV(QDIV)) u_qtick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    tw_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .job      (job),
        .tick     (tick),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .busy     (busy),
        .nack_evt (nack_evt),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    assign scl_pull_low = !scl_lvl;
    assign sda_pull_low = !sda_lvl;

endmodule

// File: tb/tw_host_master_bench.sv
`timescale 1ns/1ps
module tw_host_master_bench;

    localparam int QDIV = 2;
    localparam logic [6:0] SLV = 7'h52;
    localparam logic [6:0] BAD = 7'h13;
    localparam logic [1:0] A_DATA = 2'd0, A_INDEX = 2'd1, A_SLAVE = 2'd2, A_CTRL = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic scl_pl, sda_pl;
    logic sl_pull = 1'b0;

    wire bus_scl = !scl_pl;
    wire bus_sda = !(sda_pl | sl_pull);

    always #2.5 clk = !clk;

    tw_host_master #(.QDIV(QDIV)) u_tw_host_master (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .scl_pull_low (scl_pl),
        .sda_pull_low (sda_pl),
        .sda_in       (bus_sda)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // ---------------- slave model ----------------
    logic [7:0] mem [0:255];
    logic pscl = 1'b1, psda = 1'b1;
    logic [7:0] sh, txb, ptr;
    int bits = 0, phase = 0;
    bit ack_slot = 0;
    bit tb_quick = 0;
    int starts, stops, bytes_seen, mnack, bad_edges;
    int cyc = 0, last_rise, hi_start, per_min, per_max, hi_min, hi_max;

    task automatic clear_stats();
        starts = 0; stops = 0; bytes_seen = 0; mnack = 0; bad_edges = 0;
        last_rise = -1; hi_start = -1;
        per_min = 99999; per_max = 0; hi_min = 99999; hi_max = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            pscl = 1'b1; psda = 1'b1; sl_pull = 1'b0; phase = 0; ack_slot = 0; bits = 0;
        end else begin
            if (bus_scl && pscl && bus_sda != psda) begin
                if (!bus_sda) begin starts++; phase = 1; bits = 0; ack_slot = 0; end
                else begin stops++; phase = 0; ack_slot = 0; sl_pull = 1'b0; end
            end else if (bus_scl && !pscl) begin
                if (ack_slot) begin
                    if (phase == 4 && bus_sda) mnack++;
                end else if (phase != 0) begin
                    sh = {sh[6:0], bus_sda};
                    bits++;
                end
                if (last_rise >= 0) begin
                    if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                    if (cyc - last_rise > per_max) per_max = cyc - last_rise;
                end
                last_rise = cyc;
                hi_start = cyc;
            end else if (!bus_scl && pscl) begin
                if (hi_start >= 0) begin
                    if (cyc - hi_start < hi_min) hi_min = cyc - hi_start;
                    if (cyc - hi_start > hi_max) hi_max = cyc - hi_start;
                end
                if (ack_slot) begin
                    ack_slot = 0; sl_pull = 1'b0; bits = 0;
                    if (phase == 5) begin
                        phase = 4; txb = mem[ptr]; sl_pull = !txb[7];
                    end else if (phase == 4 || phase == 6) phase = 0;
                end else if (phase == 4) begin
                    if (bits < 8) sl_pull = !txb[7-bits];
                    else begin sl_pull = 1'b0; ack_slot = 1; end
                end else if (phase != 0 && bits == 8) begin
                    bytes_seen++;
                    case (phase)
                        1: begin
                            if (sh[7:1] == SLV) begin
                                sl_pull = 1'b1; ack_slot = 1;
                                phase = sh[0] ? (tb_quick ? 6 : 5) : 2;
                            end else phase = 0;
                        end
                        2: begin ptr = sh; sl_pull = 1'b1; ack_slot = 1; phase = 3; end
                        default: begin mem[ptr] = sh; ptr = ptr + 8'd1; sl_pull = 1'b1; ack_slot = 1; end
                    endcase
                end
            end else if (bus_scl && pscl && bus_sda == psda) begin
                // steady high: nothing
            end else if (!bus_scl && bus_sda != psda) begin
                // data change while low: allowed
            end
            pscl = bus_scl;
            psda = bus_sda;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int n;
        n = 0;
        do begin
            rd(A_CTRL, v);
            n++;
        end while (v[5] && n < 5000);
        check("R2 busy clears", int'(v[5]), 0);
    endtask

    task automatic launch(input logic [6:0] a, input logic r);
        clear_stats();
        wr(A_SLAVE, {a, r});
        reg_addr = A_CTRL; #1;
        check("R2 busy after launch", int'(reg_rdata[5]), 1);
    endtask

    task automatic timing_checks();
        check("R8 scl period min", per_min, 4*QDIV);
        check("R8 scl period max", per_max, 4*QDIV);
        check("R8 scl high min", hi_min, 2*QDIV);
        check("R8 scl high max", hi_max, 2*QDIV);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, idx, dat;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 5 + 1);
        clear_stats();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset register", int'(v), 0);
        end
        check("R1 scl released", int'(scl_pl), 0);
        check("R1 sda released", int'(sda_pl), 0);

        // R3 R7: byte write sweep
        for (int k = 0; k < 8; k++) begin
            idx = 8'(k * 37 + 3);
            dat = 8'(~idx ^ 8'(k << 4)) ;
            wr(A_INDEX, idx);
            wr(A_DATA, dat);
            launch(SLV, 1'b0);
            wait_idle();
            check("R3 R7 slave memory byte", int'(mem[idx]), int'(dat));
            check("R3 starts", starts, 1);
            check("R3 stops", stops, 1);
            check("R3 bytes on bus", bytes_seen, 3);
            rd(A_CTRL, v);
            check("R9 no error on ack", int'(v[4]), 0);
            rd(A_DATA, v);
            check("R3 data reg kept", int'(v), int'(dat));
            timing_checks();
        end

        // R4 R7: byte read sweep
        for (int k = 0; k < 8; k++) begin
            idx = 8'(k * 29 + 200);
            wr(A_INDEX, idx);
            wr(A_DATA, 8'h00);
            launch(SLV, 1'b1);
            wait_idle();
            rd(A_DATA, v);
            check("R4 R7 read byte", int'(v), int'(mem[idx]));
            check("R4 starts incl repeated", starts, 2);
            check("R4 stops", stops, 1);
            check("R4 master nack", mnack, 1);
            rd(A_CTRL, v);
            check("R4 no error", int'(v[4]), 0);
            timing_checks();
        end

        // R9: address nack on write, memory untouched
        mem[8'h44] = 8'h11;
        wr(A_INDEX, 8'h44);
        wr(A_DATA, 8'hEE);
        launch(BAD, 1'b0);
        wait_idle();
        rd(A_CTRL, v);
        check("R9 error set", int'(v[4]), 1);
        check("R9 stop after nack", stops, 1);
        check("R9 only address sent", bytes_seen, 1);
        check("R9 memory untouched", int'(mem[8'h44]), 8'h11);

        // R10: sticky through success and zero write
        launch(SLV, 1'b0);
        wait_idle();
        rd(A_CTRL, v);
        check("R10 sticky after success", int'(v[4]), 1);
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, v);
        check("R10 zero write keeps", int'(v[4]), 1);
        wr(A_CTRL, 8'h10);
        rd(A_CTRL, v);
        check("R10 one clears", int'(v[4]), 0);

        // R9: nack on read leaves data register
        wr(A_DATA, 8'h5C);
        launch(BAD, 1'b1);
        wait_idle();
        rd(A_DATA, v);
        check("R9 data not loaded", int'(v), 8'h5C);
        rd(A_CTRL, v);
        check("R9 read error set", int'(v[4]), 1);
        check("R9 single start", starts, 1);
        wr(A_CTRL, 8'h10);

        // R5: quick command, write direction
        tb_quick = 1;
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v);
        check("R1 quick bit reads back", int'(v), 1);
        mem[8'h33] = 8'h00;
        wr(A_INDEX, 8'h33);
        wr(A_DATA, 8'h44);
        launch(SLV, 1'b0);
        wait_idle();
        check("R5 quick one byte", bytes_seen, 1);
        check("R5 quick starts", starts, 1);
        check("R5 quick stops", stops, 1);
        check("R5 index not used", int'(mem[8'h33]), 0);
        rd(A_CTRL, v);
        check("R5 quick acked", int'(v[4]), 0);
        timing_checks();

        // R5: quick command, read direction
        launch(SLV, 1'b1);
        wait_idle();
        check("R5 quick read one byte", bytes_seen, 1);
        check("R5 quick read starts", starts, 1);
        rd(A_DATA, v);
        check("R5 quick read data kept", int'(v), 8'h44);

        // R5 R9: quick to absent slave
        launch(BAD, 1'b0);
        wait_idle();
        rd(A_CTRL, v);
        check("R5 R9 quick nack", int'(v[4]), 1);
        wr(A_CTRL, 8'h10);
        tb_quick = 0;
        rd(A_CTRL, v);
        check("R10 clear with quick off", int'(v), 0);

        // R11: writes during busy are dropped
        mem[8'h70] = 8'h00;
        mem[8'h71] = 8'h00;
        wr(A_INDEX, 8'h70);
        wr(A_DATA, 8'hA5);
        launch(SLV, 1'b0);
        wr(A_INDEX, 8'h71);
        wr(A_DATA, 8'h3C);
        wr(A_SLAVE, {SLV, 1'b1});
        wr(A_CTRL, 8'h01);
        wait_idle();
        repeat (40) @(posedge clk);
        check("R11 one start only", starts, 1);
        check("R11 original byte written", int'(mem[8'h70]), 8'hA5);
        check("R11 late byte absent", int'(mem[8'h71]), 0);
        rd(A_INDEX, v);
        check("R11 index kept", int'(v), 8'h70);
        rd(A_DATA, v);
        check("R11 data kept", int'(v), 8'hA5);
        rd(A_SLAVE, v);
        check("R11 slave kept", int'(v), int'({SLV, 1'b0}));
        rd(A_CTRL, v);
        check("R11 quick kept", int'(v), 0);

        // R6: bus idle after all traffic
        check("R6 scl idle high", int'(bus_scl), 1);
        check("R6 sda idle high", int'(bus_sda), 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule